// File: doc/BRIEF.md
# Streaming Frame Gather and Framer

This block collects a stream of complex samples into frames of `FRAME_LEN` samples, where `FRAME_LEN` is a power of two. A sample enters only on a cycle where the input strobe is high, and the strobe may drop for any number of cycles inside a frame. Once a frame holds all of its samples, the block sends it out as one unbroken burst of `FRAME_LEN` valid cycles. The samples leave in the order they arrived, with their values unchanged. A one-cycle start-of-frame marker comes with the first sample of each burst, and a one-cycle end-of-frame marker comes with the last.

Storage is split into two banks. One bank fills while the other drains. A bank that finishes draining can take a new sample on the same edge, so a stream running at one sample per cycle is never refused. The write side uses a bank counter and a slot counter. The read side is a two-state machine with the following states and transitions:
- `DR_IDLE`: waits for the bank it points at to be full. The transition `idle->run` happens when that bank is full.
- `DR_RUN`: emits one slot per cycle. On the last slot it releases the bank and moves to the other bank. It stays in `DR_RUN` (`run->run`) if the other bank is already full, and otherwise goes back to `DR_IDLE` (`run->idle`).

The synchronous reset input stops whatever is in progress and clears all state. The next frame starts with the first valid sample after the reset is released.

Top module: `frame_gather`

## Requirements
- R1: A sample is stored only on a rising edge where `vld_i` is high. The values on the data inputs in any other cycle never appear at the output.
- R2: No output appears until `FRAME_LEN` valid samples have been collected, however far apart those samples arrive.
- R3: Each output frame is exactly `FRAME_LEN` consecutive cycles with `vld_o` high and no gap.
- R4: `sof_o` is high for exactly one cycle per frame, together with the first `vld_o` of that frame.
- R5: `eof_o` is high for exactly one cycle per frame, together with the last `vld_o` of that frame.
- R6: With contiguous input, the first `vld_o` becomes visible after the rising edge that comes `FRAME_LEN`+1 edges after the edge that captured the first sample.
- R7: Input at one sample per cycle across several frames is always accepted. No sample is lost, and the output frames follow each other with no idle cycle between them.
- R8: A high `rst_i` discards a partly filled frame. The next frame is made from the first `FRAME_LEN` valid samples after `rst_i` goes low.
- R9: A high `rst_i` during an output burst stops it. `vld_o`, `sof_o` and `eof_o` are low from the following cycle on, and the rest of the frame never comes out.
- R10: Output samples keep the arrival order within a frame. Each sample's real and imaginary parts are unchanged.
- R11: After reset, `vld_o`, `sof_o`, `eof_o` and both data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all logic acts on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high; aborts frames and clears state |
| vld_i | input | 1 | Input sample strobe |
| din_re_i | input | DATA_W | Real part of the input sample |
| din_im_i | input | DATA_W | Imaginary part of the input sample |
| vld_o | output | 1 | Output sample strobe |
| dout_re_o | output | DATA_W | Real part of the output sample |
| dout_im_o | output | DATA_W | Imaginary part of the output sample |
| sof_o | output | 1 | High with the first sample of an output frame |
| eof_o | output | 1 | High with the last sample of an output frame |

## Verification
The hardest situation to reach is the edge where the drain releases a bank and the writer, which has just wrapped, stores its first sample into that same bank. This only happens when input runs at full rate with no gap across a frame boundary. The bench reaches it by streaming three whole frames at one sample per cycle with no pause. It then checks that all samples come out in order, and that the start and end markers fall on frame boundaries with no idle cycle between bursts. Resets in the middle of a fill and in the middle of a drain are driven at chosen cycles, so the bench can check both the discarded partial frame and the cut-off burst.

// File: rtl/fg_pkg.sv
package fg_pkg;
    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_RUN  = 1'b1
    } drain_st_e;

    localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/fg_fill.sv
module fg_fill #(
    parameter int unsigned FRAME_LEN = 64,
    localparam int unsigned CNT_W = $clog2(FRAME_LEN)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             vld_i,
    input  logic [1:0]       bank_free_i,
    output logic             we_o,
    output logic             wr_bank_o,
    output logic [CNT_W-1:0] wr_addr_o,
    output logic             frame_done_o
);
    logic [CNT_W-1:0] slot_q;
    logic             bank_q;
    logic             last_slot;

    assign last_slot    = (slot_q == CNT_W'(FRAME_LEN - 1));
    assign we_o         = vld_i && bank_free_i[bank_q];
    assign wr_bank_o    = bank_q;
    assign wr_addr_o    = slot_q;
    assign frame_done_o = we_o && last_slot;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            slot_q <= '0;
            bank_q <= 1'b0;
        end else if (we_o) begin
            if (last_slot) begin
                slot_q <= '0;
                bank_q <= ~bank_q;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    // R7
    fill_free_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_i |-> bank_free_i[bank_q]);
endmodule

// File: rtl/fg_bank_mem.sv
module fg_bank_mem #(
    parameter int unsigned FRAME_LEN = 64,
    parameter int unsigned WORD_W    = 32,
    localparam int unsigned CNT_W = $clog2(FRAME_LEN)
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic              wr_bank_i,
    input  logic [CNT_W-1:0]  wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_bank_i,
    input  logic [CNT_W-1:0]  rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o
);
    logic [WORD_W-1:0] bank_rd [fg_pkg::NUM_BANKS];

    for (genvar b = 0; b < fg_pkg::NUM_BANKS; b++) begin : g_bank
        logic [WORD_W-1:0] slots [FRAME_LEN];
        always_ff @(posedge clk_i) begin
            if (we_i && (wr_bank_i == 1'(b))) begin
                slots[wr_addr_i] <= wr_data_i;
            end
        end
        assign bank_rd[b] = slots[rd_addr_i];
    end

    assign rd_data_o = bank_rd[rd_bank_i];
endmodule

// File: rtl/fg_drain.sv
module fg_drain #(
    parameter int unsigned FRAME_LEN = 64,
    parameter int unsigned WORD_W    = 32,
    localparam int unsigned CNT_W = $clog2(FRAME_LEN)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        full_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              rd_bank_o,
    output logic [CNT_W-1:0]  rd_addr_o,
    output logic              release_o,
    output logic              vld_o,
    output logic [WORD_W-1:0] data_o,
    output logic              sof_o,
    output logic              eof_o
);
    import fg_pkg::*;

    drain_st_e        st_q, st_n;
    logic [CNT_W-1:0] pos_q, pos_n;
    logic             bank_q, bank_n;
    logic             last_pos;

    assign last_pos  = (pos_q == CNT_W'(FRAME_LEN - 1));
    assign rd_bank_o = bank_q;
    assign rd_addr_o = pos_q;

    always_comb begin
        st_n      = st_q;
        pos_n     = pos_q;
        bank_n    = bank_q;
        release_o = 1'b0;
        unique case (st_q)
            DR_IDLE: begin
                if (full_i[bank_q]) begin
                    st_n  = DR_RUN;
                    pos_n = '0;
                end
            end
            DR_RUN: begin
                if (last_pos) begin
                    release_o = 1'b1;
                    bank_n    = ~bank_q;
                    pos_n     = '0;
                    st_n      = full_i[~bank_q] ? DR_RUN : DR_IDLE;
                end else begin
                    pos_n = pos_q + 1'b1;
                end
            end
            default: st_n = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= DR_IDLE;
            pos_q  <= '0;
            bank_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            pos_q  <= pos_n;
            bank_q <= bank_n;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            vld_o  <= 1'b0;
            sof_o  <= 1'b0;
            eof_o  <= 1'b0;
            data_o <= '0;
        end else begin
            vld_o  <= (st_q == DR_RUN);
            sof_o  <= (st_q == DR_RUN) && (pos_q == '0);
            eof_o  <= (st_q == DR_RUN) && last_pos;
            data_o <= (st_q == DR_RUN) ? rd_data_i : '0;
        end
    end

    // Checker: valid cycles counted since the last start marker.
    logic [CNT_W:0] seen_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)                seen_q <= '0;
        else if (vld_o && sof_o)  seen_q <= 1;
        else if (vld_o)           seen_q <= seen_q + 1'b1;
    end

    // R4
    sof_with_vld_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sof_o |-> vld_o);
    // R5
    eof_with_vld_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        eof_o |-> vld_o);
    // R3
    no_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_o && !eof_o) |=> vld_o);
    // R3
    frame_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (eof_o && !sof_o) |-> (seen_q == (CNT_W+1)'(FRAME_LEN - 1)));
endmodule

// File: rtl/frame_gather.sv
module frame_gather #(
    parameter int unsigned FRAME_LEN = 64,
    parameter int unsigned DATA_W    = 16,
    localparam int unsigned CNT_W  = $clog2(FRAME_LEN),
    localparam int unsigned WORD_W = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] din_re_i,
    input  logic [DATA_W-1:0] din_im_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] dout_re_o,
    output logic [DATA_W-1:0] dout_im_o,
    output logic              sof_o,
    output logic              eof_o
);
    logic             we, wr_bank, frame_done;
    logic [CNT_W-1:0] wr_addr, rd_addr;
    logic             rd_bank, release_bank;
    logic [1:0]       full_q, bank_free;
    logic [WORD_W-1:0] rd_data, out_word;

    for (genvar b = 0; b < fg_pkg::NUM_BANKS; b++) begin : g_status
        assign bank_free[b] = !full_q[b] || (release_bank && (rd_bank == 1'(b)));
        always_ff @(posedge clk_i) begin
            if (rst_i)                                        full_q[b] <= 1'b0;
            else if (frame_done && (wr_bank == 1'(b)))        full_q[b] <= 1'b1;
            else if (release_bank && (rd_bank == 1'(b)))      full_q[b] <= 1'b0;
        end
    end

    fg_fill #(.FRAME_LEN(FRAME_LEN)) u_fill (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .vld_i        (vld_i),
        .bank_free_i  (bank_free),
        .we_o         (we),
        .wr_bank_o    (wr_bank),
        .wr_addr_o    (wr_addr),
        .frame_done_o (frame_done)
    );

    fg_bank_mem #(.FRAME_LEN(FRAME_LEN), .WORD_W(WORD_W)) u_mem (
        .clk_i     (clk_i),
        .we_i      (we),
        .wr_bank_i (wr_bank),
        .wr_addr_i (wr_addr),
        .wr_data_i ({din_re_i, din_im_i}),
        .rd_bank_i (rd_bank),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    fg_drain #(.FRAME_LEN(FRAME_LEN), .WORD_W(WORD_W)) u_drain (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .full_i    (full_q),
        .rd_data_i (rd_data),
        .rd_bank_o (rd_bank),
        .rd_addr_o (rd_addr),
        .release_o (release_bank),
        .vld_o     (vld_o),
        .data_o    (out_word),
        .sof_o     (sof_o),
        .eof_o     (eof_o)
    );

    assign dout_re_o = out_word[WORD_W-1:DATA_W];
    assign dout_im_o = out_word[DATA_W-1:0];

    // R7
    release_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        release_bank |-> full_q[rd_bank]);
endmodule

// File: tb/frame_gather_tb_top.sv
module frame_gather_tb_top;
    localparam int N  = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          vld_i;
    logic [DW-1:0] din_re, din_im;
    logic          vld_o, sof_o, eof_o;
    logic [DW-1:0] dout_re, dout_im;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    int          mon_n = 0;
    logic [DW-1:0] m_re [64];
    logic [DW-1:0] m_im [64];
    logic        m_sof [64];
    logic        m_eof [64];
    int          m_cyc [64];

    always #2.5 clk = ~clk;

    frame_gather #(.FRAME_LEN(N), .DATA_W(DW)) dut_i (
        .clk_i(clk), .rst_i(rst), .vld_i(vld_i),
        .din_re_i(din_re), .din_im_i(din_im),
        .vld_o(vld_o), .dout_re_o(dout_re), .dout_im_o(dout_im),
        .sof_o(sof_o), .eof_o(eof_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (vld_o && mon_n < 64) begin
            m_re[mon_n]  = dout_re;
            m_im[mon_n]  = dout_im;
            m_sof[mon_n] = sof_o;
            m_eof[mon_n] = eof_o;
            m_cyc[mon_n] = cyc;
            mon_n        = mon_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] re_of(input int base, input int i);
        return DW'(base + i);
    endfunction
    function automatic logic [DW-1:0] im_of(input int base, input int i);
        return DW'(16'hA000 ^ (base * 3 + i));
    endfunction

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            vld_i = 1'b0;
            din_re = 16'hDEAD;
            din_im = 16'hBEEF;
        end
    endtask

    task automatic send(input int base, input int i);
        @(negedge clk);
        vld_i  = 1'b1;
        din_re = re_of(base, i);
        din_im = im_of(base, i);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; vld_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        mon_n = 0;
    endtask

    task automatic check_frames(input int base, input int nfr, input string tag);
        chk(mon_n == nfr * N, {tag, " count"}, mon_n, nfr * N);
        for (int i = 0; i < nfr * N && i < mon_n; i++) begin
            chk(m_re[i] == re_of(base, i) && m_im[i] == im_of(base, i),
                {tag, " R10 data"}, int'(m_re[i]), int'(re_of(base, i)));
            chk(m_sof[i] == ((i % N) == 0), {tag, " R4 sof"}, m_sof[i], (i % N) == 0);
            chk(m_eof[i] == ((i % N) == N - 1), {tag, " R5 eof"}, m_eof[i], (i % N) == N - 1);
            if (i > 0)
                chk(m_cyc[i] == m_cyc[i-1] + 1, {tag, " R3 contiguous"}, m_cyc[i], m_cyc[i-1] + 1);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk(!vld_o && !sof_o && !eof_o && dout_re == 0 && dout_im == 0,
            "R11 reset outputs", {vld_o, sof_o, eof_o}, 0);
    endtask

    task automatic t_contig();
        int cap;
        do_reset();
        for (int i = 0; i < N; i++) begin
            send(100, i);
            if (i == 0) cap = cyc + 1;
        end
        idle(3 * N);
        check_frames(100, 1, "contig");
        chk(mon_n > 0 && m_cyc[0] == cap + N + 1, "R6 latency", m_cyc[0] - cap, N + 1);
    endtask

    task automatic t_gappy();
        do_reset();
        for (int i = 0; i < N; i++) begin
            send(300, i);
            idle((i % 3) + 1);
            if (i == N - 2) begin
                idle(20);
                chk(mon_n == 0, "R2 held until full", mon_n, 0);
            end
        end
        idle(3 * N);
        check_frames(300, 1, "gappy R1");
    endtask

    task automatic t_back2back();
        do_reset();
        for (int i = 0; i < 3 * N; i++) send(500, i);
        idle(4 * N);
        check_frames(500, 3, "R7 full rate");
    endtask

    task automatic t_abort_fill();
        do_reset();
        for (int i = 0; i < 5; i++) send(700, i);
        @(negedge clk);
        rst = 1'b1; vld_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        idle(2);
        for (int i = 0; i < N; i++) send(900, i);
        idle(3 * N);
        check_frames(900, 1, "R8 abort fill");
    endtask

    task automatic t_abort_drain();
        int seen;
        do_reset();
        for (int i = 0; i < N; i++) send(1100, i);
        idle(1);
        while (mon_n < 3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!vld_o && !sof_o && !eof_o, "R9 burst stops", vld_o, 0);
        seen = mon_n;
        idle(3 * N);
        chk(mon_n == seen, "R9 no remainder", mon_n, seen);
    endtask

    initial begin
        rst = 1'b1; vld_i = 1'b0; din_re = '0; din_im = '0;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_contig();
        t_gappy();
        t_back2back();
        t_abort_fill();
        t_abort_drain();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule